// File: doc/BRIEF.md
# Octant Tangential Coil Code Mapper

This block converts a 10-bit pointer angle into drive codes for the two coils of a crossed-coil meter movement. The full turn is cut into eight 45° octants. The three top bits of the angle choose the octant, and the seven low bits choose one of 128 steps inside it. In every octant one coil sits at full-scale magnitude and the other one follows a tangent curve. The octant sets which coil varies, which way its magnitude runs, and the sign of each coil.

Each coil comes out as a sign bit and a 7-bit magnitude, with full scale equal to 127. A downstream converter turns these codes into coil voltages. The tangent magnitudes are computed at elaboration into a constant table, so no table file or hand-typed list is needed. The block registers its result. An accepted angle produces a result one clock later, and that result stays on the outputs until the next accepted angle.

The design is a pipeline with no sequencing, so it has no state machine. The octant is an enumerated type with eight named bands: `OCT_000`, `OCT_045`, `OCT_090`, `OCT_135`, `OCT_180`, `OCT_225`, `OCT_270` and `OCT_315`. The only transitions are the capture of a new result when `angle_valid` is high, and holding the current result when it is low.

Top module: `gauge_coil_mapper`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted angle, `coil_valid`, `sin_neg`, `sin_mag`, `cos_neg` and `cos_mag` are all zero.
- R2: When `angle_valid` is high in one clock cycle, `coil_valid` is high in the next cycle with the result for that angle. `coil_valid` is low after any cycle in which `angle_valid` was low.
- R3: While `angle_valid` is low, the four coil outputs keep their values, whatever `angle_code` does.
- R4: The octant is `angle_code[9:7]` and the step is f = `angle_code[6:0]`. In the even octants (0, 2, 4, 6) the table index is f. In the odd octants it is 127 - f.
- R5: The sine coil varies in octants 0, 3, 4 and 7, and the cosine coil varies in octants 1, 2, 5 and 6. The coil that does not vary has magnitude 127.
- R6: A sign bit of 1 means negative. The sine sign is 1 in octants 4 to 7. The cosine sign is 1 in octants 2 to 5.
- R7: The table entry at index i is max(1, round(127 × tan((i + 0.5) × 45°/128))). All entries lie from 1 to 126.
- R8: Code 0 gives a positive sine of magnitude 1 and a positive cosine of 127. Code 128 gives a positive sine of 127 and a positive cosine of 126.
- R9: In every valid result exactly one coil magnitude equals 127, and neither magnitude is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle_valid | input | 1 | Accept `angle_code` this cycle |
| angle_code | input | 10 | Pointer angle, 1024 steps per turn |
| coil_valid | output | 1 | A new result was captured in the last cycle |
| sin_neg | output | 1 | Sine coil sign, 1 = negative |
| sin_mag | output | 7 | Sine coil magnitude |
| cos_neg | output | 1 | Cosine coil sign, 1 = negative |
| cos_mag | output | 7 | Cosine coil magnitude |

## Verification
The bench builds the block with its default widths: a 10-bit angle, 7-bit steps and 7-bit magnitudes. With these widths the whole angle space has only 1024 codes. A back-to-back sweep of all of them therefore reaches every octant, every table index in both the rising and the falling direction, and every octant seam. Reference magnitudes come from floating-point tangent evaluation in the bench, and they are compared against the table that the design builds in integer arithmetic.

// File: rtl/gauge_map_pkg.sv
package gauge_map_pkg;

    localparam int OCT_W = 3;

    typedef enum logic [OCT_W-1:0] {
        OCT_000 = 3'd0,
        OCT_045 = 3'd1,
        OCT_090 = 3'd2,
        OCT_135 = 3'd3,
        OCT_180 = 3'd4,
        OCT_225 = 3'd5,
        OCT_270 = 3'd6,
        OCT_315 = 3'd7
    } octant_e;

    // Fixed point Q28 evaluation of round(full * tan((idx + 0.5) * pi / 4 / 2^frac_w)),
    // clamped to the range 1 .. full-1.
    function automatic int tan_code(input int idx, input int frac_w, input int full);
        longint one_q;
        longint pi_q;
        longint x;
        longint x2;
        longint ts;
        longint tc;
        longint s_acc;
        longint c_acc;
        longint num;
        longint q;
        one_q = 64'sd268435456;
        pi_q  = 64'sd843314857;
        x     = (longint'(2 * idx + 1) * pi_q) >>> (frac_w + 3);
        x2    = (x * x) / one_q;
        ts    = x;
        tc    = one_q;
        s_acc = x;
        c_acc = one_q;
        for (int k = 1; k <= 8; k++) begin
            ts    = -((ts * x2) / one_q) / longint'((2 * k) * (2 * k + 1));
            tc    = -((tc * x2) / one_q) / longint'((2 * k - 1) * (2 * k));
            s_acc = s_acc + ts;
            c_acc = c_acc + tc;
        end
        num = longint'(2 * full) * s_acc + c_acc;
        q   = num / (2 * c_acc);
        if (q < 1) q = 1;
        if (q > longint'(full - 1)) q = longint'(full - 1);
        return int'(q);
    endfunction

endpackage

// File: rtl/angle_split.sv
module angle_split
    import gauge_map_pkg::*;
#(
    parameter int ANGLE_W = 10,
    localparam int FRAC_W = ANGLE_W - OCT_W
) (
    input  logic [ANGLE_W-1:0] code,
    output octant_e            oct,
    output logic [FRAC_W-1:0]  tab_idx
);

    logic [FRAC_W-1:0] step;

    assign oct  = octant_e'(code[ANGLE_W-1 -: OCT_W]);
    assign step = code[FRAC_W-1:0];

    // Even octants sweep the table forward, odd octants sweep it backward.
    always_comb begin
        unique case (oct)
            OCT_000, OCT_090, OCT_180, OCT_270: tab_idx = step;
            OCT_045, OCT_135, OCT_225, OCT_315: tab_idx = ~step;
        endcase
    end

endmodule

// File: rtl/tan_rom.sv
module tan_rom
    import gauge_map_pkg::*;
#(
    parameter int FRAC_W = 7,
    parameter int MAG_W  = 7,
    localparam int DEPTH = 1 << FRAC_W,
    localparam int FULL  = (1 << MAG_W) - 1
) (
    input  logic [FRAC_W-1:0] idx,
    output logic [MAG_W-1:0]  mag
);

    function automatic logic [DEPTH*MAG_W-1:0] build_table();
        logic [DEPTH*MAG_W-1:0] t;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            t[i*MAG_W +: MAG_W] = MAG_W'(tan_code(i, FRAC_W, FULL));
        end
        return t;
    endfunction

    localparam logic [DEPTH*MAG_W-1:0] TABLE = build_table();

    assign mag = TABLE[int'(idx)*MAG_W +: MAG_W];

endmodule

// File: rtl/coil_steer.sv
module coil_steer
    import gauge_map_pkg::*;
#(
    parameter int MAG_W = 7,
    localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}}
) (
    input  octant_e          oct,
    input  logic [MAG_W-1:0] var_mag,
    output logic             sin_neg,
    output logic [MAG_W-1:0] sin_mag,
    output logic             cos_neg,
    output logic [MAG_W-1:0] cos_mag
);

    always_comb begin
        unique case (oct)
            OCT_000: begin sin_neg = 1'b0; sin_mag = var_mag; cos_neg = 1'b0; cos_mag = FULL;    end
            OCT_045: begin sin_neg = 1'b0; sin_mag = FULL;    cos_neg = 1'b0; cos_mag = var_mag; end
            OCT_090: begin sin_neg = 1'b0; sin_mag = FULL;    cos_neg = 1'b1; cos_mag = var_mag; end
            OCT_135: begin sin_neg = 1'b0; sin_mag = var_mag; cos_neg = 1'b1; cos_mag = FULL;    end
            OCT_180: begin sin_neg = 1'b1; sin_mag = var_mag; cos_neg = 1'b1; cos_mag = FULL;    end
            OCT_225: begin sin_neg = 1'b1; sin_mag = FULL;    cos_neg = 1'b1; cos_mag = var_mag; end
            OCT_270: begin sin_neg = 1'b1; sin_mag = FULL;    cos_neg = 1'b0; cos_mag = var_mag; end
            OCT_315: begin sin_neg = 1'b1; sin_mag = var_mag; cos_neg = 1'b0; cos_mag = FULL;    end
        endcase
    end

endmodule

// File: rtl/gauge_coil_mapper.sv
module gauge_coil_mapper
    import gauge_map_pkg::*;
#(
    parameter int ANGLE_W = 10,
    parameter int MAG_W   = 7,
    localparam int FRAC_W = ANGLE_W - OCT_W,
    localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               angle_valid,
    input  logic [ANGLE_W-1:0] angle_code,
    output logic               coil_valid,
    output logic               sin_neg,
    output logic [MAG_W-1:0]   sin_mag,
    output logic               cos_neg,
    output logic [MAG_W-1:0]   cos_mag
);

    octant_e           oct;
    logic [FRAC_W-1:0] tab_idx;
    logic [MAG_W-1:0]  var_mag;
    logic              nx_sin_neg;
    logic              nx_cos_neg;
    logic [MAG_W-1:0]  nx_sin_mag;
    logic [MAG_W-1:0]  nx_cos_mag;

    angle_split #(.ANGLE_W(ANGLE_W)) i_split (
        .code    (angle_code),
        .oct     (oct),
        .tab_idx (tab_idx)
    );

    tan_rom #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) i_rom (
        .idx (tab_idx),
        .mag (var_mag)
    );

    coil_steer #(.MAG_W(MAG_W)) i_steer (
        .oct     (oct),
        .var_mag (var_mag),
        .sin_neg (nx_sin_neg),
        .sin_mag (nx_sin_mag),
        .cos_neg (nx_cos_neg),
        .cos_mag (nx_cos_mag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coil_valid <= 1'b0;
            sin_neg    <= 1'b0;
            sin_mag    <= '0;
            cos_neg    <= 1'b0;
            cos_mag    <= '0;
        end else begin
            coil_valid <= angle_valid;
            if (angle_valid) begin
                sin_neg <= nx_sin_neg;
                sin_mag <= nx_sin_mag;
                cos_neg <= nx_cos_neg;
                cos_mag <= nx_cos_mag;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        angle_valid |=> coil_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !angle_valid |=> !coil_valid);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !angle_valid |=> ($stable(sin_mag) && $stable(cos_mag) && $stable(sin_neg) && $stable(cos_neg)));

    assert_sine_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        angle_valid |=> (sin_neg == $past(angle_code[ANGLE_W-1])));

    assert_cos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        angle_valid |=> (cos_neg == $past(angle_code[ANGLE_W-1] ^ angle_code[ANGLE_W-2])));

    assert_one_full_coil_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coil_valid |-> (((sin_mag == FULL) != (cos_mag == FULL)) && (sin_mag != '0) && (cos_mag != '0)));

endmodule

// File: tb/test_gauge_coil_mapper.sv
`timescale 1ns/1ps
module test_gauge_coil_mapper;

    localparam int ANGLE_W = 10;
    localparam int MAG_W   = 7;
    localparam int FULL    = 127;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             angle_valid = 1'b0;
    logic [ANGLE_W-1:0] angle_code = '0;
    logic             coil_valid;
    logic             sin_neg;
    logic [MAG_W-1:0] sin_mag;
    logic             cos_neg;
    logic [MAG_W-1:0] cos_mag;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_exp = '0;

    always #4 clk = ~clk;

    gauge_coil_mapper #(.ANGLE_W(ANGLE_W), .MAG_W(MAG_W)) i_gauge_coil_mapper (
        .clk         (clk),
        .rst_n       (rst_n),
        .angle_valid (angle_valid),
        .angle_code  (angle_code),
        .coil_valid  (coil_valid),
        .sin_neg     (sin_neg),
        .sin_mag     (sin_mag),
        .cos_neg     (cos_neg),
        .cos_mag     (cos_mag)
    );

    wire [15:0] got = {sin_neg, sin_mag, cos_neg, cos_mag};

    // R7 reference magnitude
    function automatic int ref_mag(input int idx);
        real a;
        int  m;
        a = (real'(idx) + 0.5) * 45.0 / 128.0 * 3.14159265358979 / 180.0;
        m = $rtoi(127.0 * $tan(a) + 0.5);
        if (m < 1) m = 1;
        return m;
    endfunction

    // R4 R5 R6 reference steering
    function automatic logic [15:0] ref_out(input int code);
        int oct;
        int f;
        int idx;
        int vm;
        logic sn;
        logic cn;
        logic [6:0] sm;
        logic [6:0] cm;
        oct = code / 128;
        f   = code % 128;
        idx = (oct % 2 == 0) ? f : 127 - f;
        vm  = ref_mag(idx);
        sn  = (oct >= 4);
        cn  = (oct >= 2 && oct <= 5);
        if (oct == 0 || oct == 3 || oct == 4 || oct == 7) begin
            sm = 7'(vm); cm = 7'(FULL);
        end else begin
            sm = 7'(FULL); cm = 7'(vm);
        end
        return {sn, sm, cn, cm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input int code);
        @(negedge clk);
        angle_valid = 1'b1;
        angle_code  = ANGLE_W'(code);
        last_exp    = ref_out(code);
        exp_q.push_back(last_exp);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        angle_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && coil_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 result without accepted angle", got, 16'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(got == e, "R4 R5 R6 R7 coil mapping", got, e);
                check(((sin_mag == 7'(FULL)) != (cos_mag == 7'(FULL))) && sin_mag != 0 && cos_mag != 0,
                      "R9 exactly one full-scale coil, none zero", got, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({coil_valid, got} == 17'h0, "R1 outputs zero in reset", {15'h0, coil_valid}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({coil_valid, got} == 17'h0, "R1 outputs zero after release", got, 16'h0);

        // R8 corner codes
        drive(0);
        idle(2);
        check(got == {1'b0, 7'd1, 1'b0, 7'd127}, "R8 code 0", got, {1'b0, 7'd1, 1'b0, 7'd127});
        check(coil_valid == 1'b0, "R2 valid drops after idle", {15'h0, coil_valid}, 16'h0);
        drive(128);
        idle(2);
        check(got == {1'b0, 7'd127, 1'b0, 7'd126}, "R8 code 128", got, {1'b0, 7'd127, 1'b0, 7'd126});

        // R3: code changes while not valid
        angle_code = 10'd700;
        repeat (3) @(negedge clk);
        angle_code = 10'd300;
        repeat (2) @(negedge clk);
        check(got == last_exp, "R3 hold while angle_valid low", got, last_exp);

        // Octant seams with gaps
        for (int k = 0; k < 8; k++) begin
            drive(k * 128 + 127);
            idle(1);
            drive(k * 128);
            idle(3);
        end

        // Full sweep, back to back
        for (int c = 0; c < 1024; c++) drive(c);
        idle(4);
        check(exp_q.size() == 0, "R2 every accepted angle produced one result",
              16'(exp_q.size()), 16'h0);
        check(got == ref_out(1023), "R3 last result held after sweep", got, ref_out(1023));

        // Reverse order, sparse
        for (int c = 1023; c >= 0; c -= 37) begin
            drive(c);
            idle(2);
        end
        idle(3);
        check(exp_q.size() == 0, "R2 sparse results drained", 16'(exp_q.size()), 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule